// File: doc/BRIEF.md
# Sensor Status Byte with Clear-on-Read Flags

This block builds the 8-bit read-only status byte of an inertial sensor's control logic. It takes the device phase and the error, end-of-initialization and test-mode indications as live inputs. Every field is registered once, so the byte shows each input one clock after the input changes. The two top bits carry an encoded phase, in which a detected error takes priority over every other phase.

Several fields are sticky flags with different lifetimes. A flag for a forbidden end-of-initialization write and a flag for a soft-reset event hold until a read strobe clears them. A capacitor-loss flag is captured only inside a power-up window, which a counter times from the release of the power-on reset, and a read does not clear it. A separate flag marks the end of that power-up window. A read returns the byte as it stood before the clear takes effect. When a flag is set in the same cycle as a read, the flag stays set.

Top module: `sensor_status_reg`

## Requirements
- R1: While rst_n is low and until the first update after it is released, status_o reads 0x00.
- R2: status_o[7:6] shows the value phase_i had one cycle earlier, with err_i low: 2'b10 for phase_i=2 (test); 2'b01 for phase_i=1 (normal) with eoi_i=1; 2'b00 for phase_i=0 (init), for phase_i=3, and for phase_i=1 with eoi_i=0.
- R3: When err_i was 1 in the previous cycle, status_o[7:6] is 2'b11, whatever phase_i, eoi_i and test_mode_i are.
- R4: status_o[5] equals test_mode_i from the previous cycle.
- R5: status_o[4] becomes 1 the cycle after eoi_wr_i=1 while any bit of st_pos_i or st_neg_i is 1. An eoi_wr_i pulse while no channel is in self-test leaves the bit unchanged.
- R6: A read (rd_i=1 for one cycle) returns the byte as it stood before the read. Bits 4 and 0 are 0 in the following cycle, unless a new set event occurs.
- R7: When a set event for bit 4 or bit 0 occurs in the same cycle as a read, that bit is 1 in the next cycle.
- R8: status_o[3] always reads 0.
- R9: Let W = CLK_HZ/1_000_000*WIN_US. cap_loss_i is sampled only on the W clock edges that follow the second rising clock edge after rst_n goes high. A sampled 1 sets status_o[2], and cap_loss_i is ignored on every later edge.
- R10: status_o[2] stays set until rst_n is asserted, and reads do not clear it.
- R11: status_o[1] is 0 until the end of the capture window. It becomes 1 after the (W+2)-th rising edge following the release of rst_n, and stays 1.
- R12: status_o[0] becomes 1 the cycle after a soft_rst_i pulse and is cleared by a read, following R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| phase_i | input | 2 | Device phase: 0 init, 1 normal, 2 test, 3 treated as init |
| err_i | input | 1 | Error detected in the device |
| eoi_i | input | 1 | Current end-of-initialization bit |
| test_mode_i | input | 1 | Device is in test mode |
| eoi_wr_i | input | 1 | Pulse: attempted write of end-of-initialization = 1 |
| st_pos_i | input | NCH | Per-channel positive self-test active |
| st_neg_i | input | NCH | Per-channel negative self-test active |
| soft_rst_i | input | 1 | Pulse: a soft reset sequence has run |
| cap_loss_i | input | 1 | Capacitor-loss detector output |
| rd_i | input | 1 | Read strobe for the status byte |
| status_o | output | 8 | Composed status byte |

## Verification
On every cycle, the embedded properties check the following. A set event always leaves its flag at 1 in the next cycle. A read without a set clears the clear-on-read flags. The capacitor-loss bit cannot rise once the window has closed. The end-of-window bit never falls. A registered error always shows as 2'b11 in the phase field. Only the bench scenarios can show the exact edge on which the window opens and closes, each phase encoding with its end-of-init qualification, and the fact that a read returns the byte from before the clear. The bench also shows that the capacitor-loss bit survives repeated reads.

// File: rtl/sstat_pkg.sv
`timescale 1ns/1ps
package sstat_pkg;
  typedef enum logic [1:0] {
    PH_INIT   = 2'd0,
    PH_NORMAL = 2'd1,
    PH_TEST   = 2'd2,
    PH_RSVD   = 2'd3
  } phase_e;

  localparam logic [1:0] CODE_INIT = 2'b00;
  localparam logic [1:0] CODE_NORM = 2'b01;
  localparam logic [1:0] CODE_TEST = 2'b10;
  localparam logic [1:0] CODE_ERR  = 2'b11;

  localparam int unsigned STATUS_W = 8;
endpackage

// File: rtl/sstat_pwrup_timer.sv
`timescale 1ns/1ps
module sstat_pwrup_timer #(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned WIN_US = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_active_o,
  output logic done_o
);
  localparam int unsigned WIN_CYC = (CLK_HZ / 1_000_000) * WIN_US;
  localparam int unsigned CNT_W   = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en       = (cnt_q != CNT_END);
  assign win_active_o = cnt_en;
  assign done_o       = ~cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R11
endmodule

// File: rtl/sstat_flag.sv
`timescale 1ns/1ps
module sstat_flag #(
  parameter bit CLR_ON_RD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  output logic q_o
);
  logic q_q, q_d;

  generate
    if (CLR_ON_RD) begin : g_rdclr
      always_comb begin
        q_d = q_q;
        if (set_i)     q_d = 1'b1;
        else if (rd_i) q_d = 1'b0;
      end
      AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !set_i) |=> !q_o); // R6
    end else begin : g_hold
      always_comb begin
        q_d = q_q;
        if (set_i) q_d = 1'b1;
      end
      AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        q_o |=> q_o); // R10
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R7
endmodule

// File: rtl/sstat_phase_enc.sv
`timescale 1ns/1ps
module sstat_phase_enc
  import sstat_pkg::*;
(
  input  phase_e     phase_i,
  input  logic       eoi_i,
  input  logic       err_i,
  output logic [1:0] code_o
);
  always_comb begin
    if (err_i) begin
      code_o = CODE_ERR;
    end else begin
      unique case (phase_i)
        PH_TEST:   code_o = CODE_TEST;
        PH_NORMAL: code_o = eoi_i ? CODE_NORM : CODE_INIT;
        default:   code_o = CODE_INIT;
      endcase
    end
  end
endmodule

// File: rtl/sensor_status_reg.sv
`timescale 1ns/1ps
module sensor_status_reg
  import sstat_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned WIN_US = 400,
  parameter int unsigned NCH    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          phase_i,
  input  logic                err_i,
  input  logic                eoi_i,
  input  logic                test_mode_i,
  input  logic                eoi_wr_i,
  input  logic [NCH-1:0]      st_pos_i,
  input  logic [NCH-1:0]      st_neg_i,
  input  logic                soft_rst_i,
  input  logic                cap_loss_i,
  input  logic                rd_i,
  output logic [STATUS_W-1:0] status_o
);
  // reset: asynchronous assertion, release aligned to the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // phase field and test-mode bit
  logic [1:0] code_d, code_q;
  logic       tm_q;

  sstat_phase_enc u_enc (
    .phase_i (phase_e'(phase_i)),
    .eoi_i   (eoi_i),
    .err_i   (err_i),
    .code_o  (code_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      code_q <= CODE_INIT;
      tm_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      tm_q   <= test_mode_i;
    end
  end

  // power-up capture window
  logic win_active, pwrup_done;

  sstat_pwrup_timer #(.CLK_HZ(CLK_HZ), .WIN_US(WIN_US)) u_timer (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .win_active_o (win_active),
    .done_o       (pwrup_done)
  );

  // sticky flags
  logic st_any, wr_err_set, cap_set;
  logic wr_err_q, cap_q, srst_q;

  assign st_any     = (|st_pos_i) | (|st_neg_i);
  assign wr_err_set = eoi_wr_i & st_any;
  assign cap_set    = cap_loss_i & win_active;

  sstat_flag #(.CLR_ON_RD(1'b1)) u_wr_err (
    .clk (clk), .rst_n (rst_int_n), .set_i (wr_err_set), .rd_i (rd_i), .q_o (wr_err_q)
  );

  sstat_flag #(.CLR_ON_RD(1'b0)) u_cap (
    .clk (clk), .rst_n (rst_int_n), .set_i (cap_set), .rd_i (rd_i), .q_o (cap_q)
  );

  sstat_flag #(.CLR_ON_RD(1'b1)) u_srst (
    .clk (clk), .rst_n (rst_int_n), .set_i (soft_rst_i), .rd_i (rd_i), .q_o (srst_q)
  );

  assign status_o = {code_q, tm_q, wr_err_q, 1'b0, cap_q, pwrup_done, srst_q};

  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_i |=> (status_o[7:6] == CODE_ERR)); // R3
  AST_CAP_CLOSED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!win_active && !cap_q) |=> !status_o[2]); // R9
  AST_TM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    test_mode_i |=> status_o[5]); // R4
  AST_NO_SPURIOUS_WERR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_err_q && !(eoi_wr_i && st_any)) |=> !status_o[4]); // R5
endmodule

// File: tb/test_sensor_status_reg.sv
`timescale 1ns/1ps
module test_sensor_status_reg;
  localparam int unsigned NCH = 2;
  localparam int unsigned W   = 50;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     phase_i = 2'd0;
  logic           err_i = 1'b0, eoi_i = 1'b0, test_mode_i = 1'b0, eoi_wr_i = 1'b0;
  logic [NCH-1:0] st_pos_i = '0, st_neg_i = '0;
  logic           soft_rst_i = 1'b0, cap_loss_i = 1'b0, rd_i = 1'b0;
  logic [7:0]     status_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sensor_status_reg #(.CLK_HZ(1_000_000), .WIN_US(W), .NCH(NCH)) i_sensor_status_reg (
    .clk (clk), .rst_n (rst_n), .phase_i (phase_i), .err_i (err_i), .eoi_i (eoi_i),
    .test_mode_i (test_mode_i), .eoi_wr_i (eoi_wr_i), .st_pos_i (st_pos_i),
    .st_neg_i (st_neg_i), .soft_rst_i (soft_rst_i), .cap_loss_i (cap_loss_i),
    .rd_i (rd_i), .status_o (status_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: issue a one-cycle read and push its expected byte
  task automatic rd_expect(input logic [7:0] exp, input string tag);
    rd_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  // monitor: compare the byte seen during each read strobe
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_i) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL unexpected read: actual=%02h expected=none", status_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (status_o !== e) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", t, status_o, e);
          end
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
  endtask

  initial begin
    do_reset();
    rd_expect(8'h00, "R1 byte zero in reset");
    rst_n = 1'b1;                  // released before edge E1
    step(2);
    rd_expect(8'h00, "R1 byte zero right after release");   // ends after E3
    step(W - 2);                   // after E(1+W)
    rd_expect(8'h00, "R11 window not yet closed, R8 bit3 zero");
    cap_loss_i = 1'b1;             // sampled at E(3+W): outside window
    rd_expect(8'h02, "R11 end of power-up flag set");
    cap_loss_i = 1'b0;
    step(1);
    rd_expect(8'h02, "R9 capacitor loss ignored after window");

    // second power-up: detector asserted on the last window edge
    do_reset();
    rst_n = 1'b1;
    step(1 + W);                   // after E(1+W)
    cap_loss_i = 1'b1;             // sampled at E(2+W): last window edge
    step(1);
    cap_loss_i = 1'b0;
    step(1);
    rd_expect(8'h06, "R9 capacitor loss captured in window");
    rd_expect(8'h06, "R10 capacitor loss survives read");

    // phase encoding
    phase_i = 2'd1; eoi_i = 1'b1; step(1);
    rd_expect(8'h46, "R2 normal with end-of-init");
    eoi_i = 1'b0; step(1);
    rd_expect(8'h06, "R2 normal without end-of-init");
    phase_i = 2'd3; step(1);
    rd_expect(8'h06, "R2 reserved phase reads init");
    phase_i = 2'd2; test_mode_i = 1'b1; step(1);
    rd_expect(8'hA6, "R2 R4 test phase and test-mode bit");
    err_i = 1'b1; step(1);
    rd_expect(8'hE6, "R3 error overrides test phase");
    phase_i = 2'd1; eoi_i = 1'b1; test_mode_i = 1'b0; step(1);
    rd_expect(8'hC6, "R3 error overrides normal phase");
    err_i = 1'b0; phase_i = 2'd0; eoi_i = 1'b0; step(1);
    rd_expect(8'h06, "R2 back to init");

    // forbidden end-of-init write
    eoi_wr_i = 1'b1; st_pos_i = 2'b01; step(1);
    eoi_wr_i = 1'b0; st_pos_i = '0;
    rd_expect(8'h16, "R5 write error set by positive self-test");
    rd_expect(8'h06, "R6 write error cleared by read");
    eoi_wr_i = 1'b1; step(1);
    eoi_wr_i = 1'b0;
    rd_expect(8'h06, "R5 write with no self-test ignored");
    st_neg_i = 2'b10; step(1);
    eoi_wr_i = 1'b1; step(1);
    eoi_wr_i = 1'b0; st_neg_i = '0;
    rd_expect(8'h16, "R5 write error set by negative self-test ch1");
    rd_expect(8'h06, "R6 write error cleared");

    // set and read in the same cycle
    eoi_wr_i = 1'b1; st_pos_i = 2'b10;
    rd_expect(8'h06, "R6 read returns pre-update byte");
    eoi_wr_i = 1'b0; st_pos_i = '0;
    rd_expect(8'h16, "R7 set wins over simultaneous read");
    rd_expect(8'h06, "R6 cleared after later read");

    // soft reset flag
    soft_rst_i = 1'b1; step(1);
    soft_rst_i = 1'b0;
    rd_expect(8'h07, "R12 soft reset flag set");
    rd_expect(8'h06, "R12 soft reset flag cleared by read");
    soft_rst_i = 1'b1;
    rd_expect(8'h06, "R12 read before simultaneous set");
    soft_rst_i = 1'b0;
    rd_expect(8'h07, "R7 R12 soft reset set wins over read");
    rd_expect(8'h06, "R12 cleared again");

    step(2);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R6 pending reads: actual=%0d expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule